// File: doc/BRIEF.md
# Ping-Pong Sample Buffer Controller

This block takes a stream of PCM samples and stores them in one memory that is
treated as two equal halves. The writer fills the lower half, signals that it is
done, moves on to the upper half, signals again, and then wraps back to the
bottom of the lower half. This continues for as long as samples arrive. A
consumer works on whichever half was most recently filled while the writer is
busy in the other one.

Each half carries a busy bit. The bit is set when its fill event fires and
cleared when the consumer pulses that half's release input. A half is still busy
if the writer comes back to it before the consumer has released it. In that case
the consumer has missed its deadline: a sticky overrun flag is raised and the
sample is written anyway. The consumer reads the memory through its own port,
at any address, with a registered read.

Top module: `pp_sample_buf`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 2'b00, `overrun` is 0, `evt_half` and `evt_full` are 0, and `last_half` is 0.
- R2: Each cycle in which `in_valid` is high writes `in_data` to the current write address. The address starts at 0 after reset and steps by one per write, through 2*HALF_DEPTH-1. A cycle with `in_valid` low writes nothing and does not move the address.
- R3: The cycle after the write to address HALF_DEPTH-1, `evt_half` is high for exactly one cycle, `busy[0]` is set, and `last_half` becomes 0.
- R4: The cycle after the write to address 2*HALF_DEPTH-1, `evt_full` is high for exactly one cycle, `busy[1]` is set, and `last_half` becomes 1. The next write goes to address 0.
- R5: A one-cycle pulse on `rel_lo` (or `rel_hi`) clears `busy[0]` (or `busy[1]`) in the following cycle. If the release arrives in the same cycle as the write that fills that half, the set wins and the bit ends up 1.
- R6: A write to address 0 while `busy[0]` is 1, or to address HALF_DEPTH while `busy[1]` is 1, sets `overrun` in the following cycle, unless the same half's release is pulsed in that cycle. The sample is stored in either case.
- R7: `overrun` stays at 1 until a cycle with `ovr_clr` high, after which it reads 0. If a new overrun occurs in the same cycle as `ovr_clr`, `overrun` stays 1.
- R8: `rd_data` shows, one cycle later, the word that was at `rd_addr` at the clock edge. If the same address is written at that edge, the old word is returned.
- R9: `evt_half` and `evt_full` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | DATA_W | Sample value |
| rel_lo | input | 1 | Consumer release pulse for the lower half |
| rel_hi | input | 1 | Consumer release pulse for the upper half |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_addr | input | ADDR_W | Consumer read address |
| rd_data | output | DATA_W | Registered read data |
| evt_half | output | 1 | Pulse: lower half filled |
| evt_full | output | 1 | Pulse: upper half filled |
| last_half | output | 1 | Most recently filled half (0 lower, 1 upper) |
| busy | output | 2 | Per-half busy bits, bit 0 for the lower half |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A directed opening first fills the lower half with its release pulsed in the same
cycle as the filling write, which shows whether set takes priority over release.
A mid-buffer release then lets the writer wrap into the lower half cleanly, and
an unreleased upper half then forces an overrun. This separates correct busy
handling from a writer that ignores it. A clear followed by a clear that collides
with a fresh overrun shows whether the flag is sticky and which input has
priority. After that, a long run of sparse-to-dense sample strobes, random
release and clear pulses, and random read addresses is checked against a bench
model. This run catches pointer stalls, event timing that is off by one, and
read-before-write errors.

// File: rtl/pp_pkg.sv
// Package shared by the ping-pong buffer blocks.
// Assumes: exactly two halves, indexed 0 (lower) and 1 (upper).
package pp_pkg;
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    localparam int NUM_HALVES = 2;
endpackage

// File: rtl/pp_wr_ctrl.sv
// Write pointer for the two-half buffer. For the write happening in the
// current cycle it reports whether that write enters a half (first address)
// or fills it (last address).
// Assumes: HALF_DEPTH >= 2; ADDR_W can hold 2*HALF_DEPTH-1.
module pp_wr_ctrl #(
    parameter int HALF_DEPTH = 64,
    parameter int ADDR_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [1:0]        enter_ev,
    output logic [1:0]        fill_ev
);
    localparam logic [ADDR_W-1:0] LO_FIRST = '0;
    localparam logic [ADDR_W-1:0] LO_LAST  = ADDR_W'(HALF_DEPTH - 1);
    localparam logic [ADDR_W-1:0] HI_FIRST = ADDR_W'(HALF_DEPTH);
    localparam logic [ADDR_W-1:0] HI_LAST  = ADDR_W'(2 * HALF_DEPTH - 1);

    logic [ADDR_W-1:0] ptr_q;

    // Advance the pointer on every write, wrapping after the upper half's last word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (wr_en)
            ptr_q <= (ptr_q == HI_LAST) ? '0 : ptr_q + 1'b1;
    end

    // Decode boundary addresses for the write in progress.
    always_comb begin
        enter_ev[0] = wr_en && (ptr_q == LO_FIRST);
        enter_ev[1] = wr_en && (ptr_q == HI_FIRST);
        fill_ev[0]  = wr_en && (ptr_q == LO_LAST);
        fill_ev[1]  = wr_en && (ptr_q == HI_LAST);
    end

    assign wr_addr = ptr_q;
endmodule

// File: rtl/pp_half_track.sv
// Per-half busy bits, the sticky overrun flag, the event pulses and the
// last-filled indicator.
// Assumes: fill_ev / enter_ev are single-cycle and come from pp_wr_ctrl.
// A set beats a release; a new overrun beats a clear.
module pp_half_track
    import pp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] enter_ev,
    input  logic [1:0] fill_ev,
    input  logic [1:0] release_i,
    input  logic       ovr_clr,
    output logic [1:0] busy,
    output logic       overrun,
    output logic       evt_half,
    output logic       evt_full,
    output logic       last_half
);
    logic [NUM_HALVES-1:0] busy_q;
    logic [NUM_HALVES-1:0] miss;
    logic                  ovr_q;
    logic                  evt_lo_q;
    logic                  evt_hi_q;
    half_e                 last_q;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        // Entering a half that the consumer still holds counts as a missed deadline.
        assign miss[h] = enter_ev[h] && busy_q[h] && !release_i[h];

        // Busy bit: set at the fill event, cleared by the consumer's release.
        always_ff @(posedge clk) begin
            if (!rst_n)
                busy_q[h] <= 1'b0;
            else if (fill_ev[h])
                busy_q[h] <= 1'b1;
            else if (release_i[h])
                busy_q[h] <= 1'b0;
        end
    end

    // Sticky overrun flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_q <= 1'b0;
        else if (|miss)
            ovr_q <= 1'b1;
        else if (ovr_clr)
            ovr_q <= 1'b0;
    end

    // Register the event pulses and remember which half filled last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_lo_q <= 1'b0;
            evt_hi_q <= 1'b0;
            last_q   <= HALF_LO;
        end else begin
            evt_lo_q <= fill_ev[0];
            evt_hi_q <= fill_ev[1];
            if (fill_ev[0])
                last_q <= HALF_LO;
            else if (fill_ev[1])
                last_q <= HALF_HI;
        end
    end

    assign busy      = busy_q;
    assign overrun   = ovr_q;
    assign evt_half  = evt_lo_q;
    assign evt_full  = evt_hi_q;
    assign last_half = (last_q == HALF_HI);
endmodule

// File: rtl/pp_dpram.sv
// Simple dual-port memory: one write port, one registered read port.
// A read and a write to the same address at one edge return the old word.
// Assumes: contents are undefined until written; only the read register is reset.
module pp_dpram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 128,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store incoming words.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    // One-cycle registered read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= mem[raddr];
    end
endmodule

// File: rtl/pp_sample_buf.sv
// Ping-pong sample buffer controller: writes a sample stream into two halves
// of one memory, flags each filled half, tracks consumer releases and detects
// overruns. The consumer reads through a separate registered port.
// Assumes: HALF_DEPTH >= 2; release and clear inputs are pulses from the
// consumer in this clock domain.
module pp_sample_buf #(
    parameter int DATA_W     = 16,
    parameter int HALF_DEPTH = 64,
    parameter int ADDR_W     = $clog2(2 * HALF_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rel_lo,
    input  logic              rel_hi,
    input  logic              ovr_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              evt_half,
    output logic              evt_full,
    output logic              last_half,
    output logic [1:0]        busy,
    output logic              overrun
);
    localparam int DEPTH = 2 * HALF_DEPTH;

    logic [ADDR_W-1:0] wr_addr;
    logic [1:0]        enter_ev;
    logic [1:0]        fill_ev;

    pp_wr_ctrl #(
        .HALF_DEPTH(HALF_DEPTH),
        .ADDR_W    (ADDR_W)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (in_valid),
        .wr_addr (wr_addr),
        .enter_ev(enter_ev),
        .fill_ev (fill_ev)
    );

    pp_half_track u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter_ev (enter_ev),
        .fill_ev  (fill_ev),
        .release_i({rel_hi, rel_lo}),
        .ovr_clr  (ovr_clr),
        .busy     (busy),
        .overrun  (overrun),
        .evt_half (evt_half),
        .evt_full (evt_full),
        .last_half(last_half)
    );

    pp_dpram #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .ADDR_W(ADDR_W)
    ) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (in_valid),
        .waddr(wr_addr),
        .wdata(in_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/pp_sample_buf_chk.sv
// Checker for pp_sample_buf, attached by bind. Observes ports only.
module pp_sample_buf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       rel_lo,
    input logic       rel_hi,
    input logic       ovr_clr,
    input logic       evt_half,
    input logic       evt_full,
    input logic       last_half,
    input logic [1:0] busy,
    input logic       overrun
);
    a_r9_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt_half && evt_full));

    a_r3_half_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_half |=> !evt_half);

    a_r4_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |=> !evt_full);

    a_r3_half_marks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_half |-> (busy[0] && !last_half));

    a_r4_full_marks: assert property (@(posedge clk) disable iff (!rst_n)
        evt_full |-> (busy[1] && last_half));

    a_r5_release_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[0] && rel_lo) |=> (!busy[0] || evt_half));

    a_r5_release_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (busy[1] && rel_hi) |=> (!busy[1] || evt_full));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    a_r6_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(in_valid));
endmodule

bind pp_sample_buf pp_sample_buf_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rel_lo   (rel_lo),
    .rel_hi   (rel_hi),
    .ovr_clr  (ovr_clr),
    .evt_half (evt_half),
    .evt_full (evt_full),
    .last_half(last_half),
    .busy     (busy),
    .overrun  (overrun)
);

// File: tb/tb_pp_sample_buf.sv
module tb_pp_sample_buf;
    localparam int DATA_W = 16;
    localparam int HALF   = 64;
    localparam int DEPTH  = 2 * HALF;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              rel_lo = 1'b0;
    logic              rel_hi = 1'b0;
    logic              ovr_clr = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              evt_half, evt_full, last_half, overrun;
    logic [1:0]        busy;

    always #10 clk = ~clk;

    pp_sample_buf #(.DATA_W(DATA_W), .HALF_DEPTH(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .rel_lo(rel_lo), .rel_hi(rel_hi), .ovr_clr(ovr_clr),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_half(evt_half),
        .evt_full(evt_full), .last_half(last_half), .busy(busy),
        .overrun(overrun)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Bench model state, derived from the requirements.
    logic [DATA_W-1:0] m_mem [DEPTH];
    bit                m_wr  [DEPTH];
    int                m_ptr;
    logic [1:0]        m_busy;
    logic              m_ovr, m_eh, m_ef, m_last;
    logic [DATA_W-1:0] m_rd;
    bit                m_rd_ok;

    task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_bit(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic model_reset();
        m_ptr = 0; m_busy = 2'b00; m_ovr = 0; m_eh = 0; m_ef = 0; m_last = 0;
        m_rd_ok = 0;
        for (int i = 0; i < DEPTH; i++) m_wr[i] = 0;
    endtask

    // Check outputs from the previous edge, then drive this cycle's inputs and
    // predict what the next edge produces.
    task automatic step(logic v, logic [DATA_W-1:0] d, logic rl, logic rh,
                        logic clr, logic [ADDR_W-1:0] ra);
        logic       f0, f1, miss;
        logic [1:0] rel;
        @(negedge clk);
        cmp("R3 evt_half", evt_half, m_eh);
        cmp("R4 evt_full", evt_full, m_ef);
        cmp("R3/R4 last_half", last_half, m_last);
        cmp("R5 busy", busy, m_busy);
        cmp("R6/R7 overrun", overrun, m_ovr);
        cmp("R9 exclusive", evt_half & evt_full, 1'b0);
        if (m_rd_ok) cmp("R2/R8 rd_data", rd_data, m_rd);
        in_valid = v; in_data = d; rel_lo = rl; rel_hi = rh; ovr_clr = clr;
        rd_addr = ra;
        rel = {rh, rl};
        m_rd_ok = m_wr[ra];
        m_rd    = m_mem[ra];
        f0 = 0; f1 = 0; miss = 0;
        if (v) begin
            if (m_ptr == 0)    miss = m_busy[0] && !rl;
            if (m_ptr == HALF) miss = m_busy[1] && !rh;
            f0 = (m_ptr == HALF - 1);
            f1 = (m_ptr == DEPTH - 1);
            m_mem[m_ptr] = d;
            m_wr[m_ptr]  = 1;
            m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
        end
        m_busy[0] = next_bit(m_busy[0], f0, rel[0]);
        m_busy[1] = next_bit(m_busy[1], f1, rel[1]);
        m_ovr  = next_bit(m_ovr, miss, clr);
        m_eh   = f0;
        m_ef   = f1;
        m_last = f0 ? 1'b0 : (f1 ? 1'b1 : m_last);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state checked by the first steps.
        step(0, 16'h0, 0, 0, 0, '0);
        // R2: idle strobes with data present must not write or advance.
        for (int i = 0; i < 4; i++) step(0, 16'hDEAD, 0, 0, 0, '0);
        // R5: fill lower half, releasing it in the same cycle as the fill write.
        for (int i = 0; i < HALF; i++)
            step(1, 16'(16'h1000 + i), (i == HALF - 1), 0, 0, ADDR_W'(i));
        // Upper half; release lower mid-way (R5 clear).
        for (int i = 0; i < HALF; i++)
            step(1, 16'(16'h2000 + i), (i == 10), 0, 0, ADDR_W'(i));
        // Lower half again without overrun, then enter busy upper half (R6).
        for (int i = 0; i < HALF + 4; i++)
            step(1, 16'(16'h3000 + i), 0, 0, 0, ADDR_W'(HALF + i));
        // R7: flag holds while idle, then clears.
        step(0, 16'h0, 0, 0, 0, '0);
        step(0, 16'h0, 0, 0, 1, '0);
        step(0, 16'h0, 0, 0, 0, '0);
        // R7: clear colliding with a new overrun on entry to the busy lower half.
        for (int i = 0; i < HALF - 4; i++)
            step(1, 16'(16'h4000 + i), 0, 0, 0, '0);
        step(1, 16'h4444, 0, 0, 1, '0);
        step(0, 16'h0, 0, 0, 0, '0);
        // Random phase with varying strobe density.
        for (int i = 0; i < 6000; i++) begin
            int dens;
            dens = (i / 1000) % 3;
            step(($urandom % 10) < (dens * 4 + 2),
                 16'($urandom),
                 ($urandom % 100) < 4,
                 ($urandom % 100) < 4,
                 ($urandom % 100) < 2,
                 ADDR_W'($urandom));
        end
        step(0, 16'h0, 0, 0, 0, '0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule